// File: doc/BRIEF.md
# Power-Fail Gated SRAM Bank Select

This block produces the two active-low chip enables for a pair of external battery-backed SRAM banks. A single active-low access enable together with one bank-select address bit chooses which bank, if any, is enabled. The two enables are never asserted together.

Two digital power-state flags take part in the decode. One reports a supply that has fallen below its power-fail threshold. The other reports that the system is running on backup battery. Both flags pass through a two-stage synchronizer. While either flag is set, both enables are forced inactive and a write-protect status output is raised. When both flags have cleared, the block keeps blocking for a programmable number of clocks. Any reassertion of a flag inside that window restarts it, which rejects glitches on a recovering supply. Reset starts the block in the blocked state, so the memory is protected until the supply flags have been seen clear for the full holdoff.

Top module: `sram_bank_gate`

## Requirements
- R1: When not blocked, with `acc_en_n` low and `bank_sel` low (bank 0), `bank0_ce_n` is low and `bank1_ce_n` is high.
- R2: When not blocked, with `acc_en_n` low and `bank_sel` high (bank 1), `bank1_ce_n` is low and `bank0_ce_n` is high. The two enables are never low at the same time.
- R3: With `acc_en_n` high, both enables are high whatever `bank_sel` is.
- R4: While blocking is active, both enables are high whatever `acc_en_n` and `bank_sel` are.
- R5: A high `pwr_fail` sampled at clock edge t makes blocking active after edge t+2: two synchronizer stages, then one register.
- R6: A high `batt_mode` blocks with the same timing as `pwr_fail` in R5.
- R7: If both flags are first sampled low at edge t, blocking ends after edge t+HOLD_CYCLES+2. A flag sampled high at any edge before that restarts the count from when it is next sampled low.
- R8: `wr_prot` is high exactly while blocking is active.
- R9: During reset and right after it, both enables are high and `wr_prot` is high. Blocking ends only after the R7 holdoff has elapsed with both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en_n | input | 1 | Access enable, active low |
| bank_sel | input | 1 | Bank-select bit: 0 selects bank 0, 1 selects bank 1 |
| pwr_fail | input | 1 | Supply below power-fail threshold, active high |
| batt_mode | input | 1 | Running on backup battery, active high |
| bank0_ce_n | output | 1 | Bank 0 chip enable, active low |
| bank1_ce_n | output | 1 | Bank 1 chip enable, active low |
| wr_prot | output | 1 | Write-protect status, high while enables are blocked |

## Verification
Several properties are checked on every clock: the two enables are never asserted together, nothing is enabled while write protection is up, a synchronized flag always leads to blocking on the next clock, an armed holdoff counter always implies blocking, and each power flag seen at the pins reaches the block after its fixed latency. The decode truth table, the exact clock on which the holdoff releases, the restart of the holdoff by a short pulse during recovery, and the protected state coming out of reset can only be shown by the bench's timed scenarios, which count clocks from each input change.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    typedef enum logic {
        BANK_LOW  = 1'b0,
        BANK_HIGH = 1'b1
    } bank_e;

    typedef struct packed {
        logic pwr_fail;
        logic batt;
    } pwr_flags_t;

    typedef struct packed {
        logic ce0_n;
        logic ce1_n;
    } bank_ce_t;

    localparam int FLAG_W = $bits(pwr_flags_t);

    localparam bank_ce_t CE_ALL_OFF = '{ce0_n: 1'b1, ce1_n: 1'b1};

    function automatic bank_ce_t decode_bank(logic en_n, bank_e sel, logic blocked);
        bank_ce_t r;
        r = CE_ALL_OFF;
        if (!blocked && !en_n) begin
            case (sel)
                BANK_LOW:  r.ce0_n = 1'b0;
                BANK_HIGH: r.ce1_n = 1'b0;
                default:   r = CE_ALL_OFF;
            endcase
        end
        return r;
    endfunction

    function automatic logic any_flag(pwr_flags_t f);
        return f.pwr_fail | f.batt;
    endfunction

endpackage

// File: rtl/sbg_sync.sv
module sbg_sync #(
    parameter int STAGES  = 2,
    parameter int WIDTH   = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= {WIDTH{RST_VAL}};
                    else     stage_q[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= {WIDTH{RST_VAL}};
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sbg_holdoff.sv
module sbg_holdoff
    import sbg_pkg::*;
#(
    parameter int HOLD_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  pwr_flags_t flags,
    output logic       blocked
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 2);
    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYCLES);

    logic             active;
    logic [CNT_W-1:0] cnt_q;
    logic             blk_q;

    assign active = any_flag(flags);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= HOLD_LD;
            blk_q <= 1'b1;
        end else begin
            if (active)              cnt_q <= HOLD_LD;
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
            blk_q <= active || (cnt_q != '0);
        end
    end

    assign blocked = blk_q;

    // R4: a synchronized power flag always blocks on the following clock
    p_flag_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        active |=> blk_q);

    // R7: while the holdoff counter is armed, blocking stays on
    p_hold_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> blk_q);

endmodule

// File: rtl/sbg_decode.sv
module sbg_decode
    import sbg_pkg::*;
(
    input  logic     en_n,
    input  logic     sel,
    input  logic     blocked,
    output bank_ce_t ce
);
    always_comb begin
        ce = decode_bank(en_n, bank_e'(sel), blocked);
    end
endmodule

// File: rtl/sram_bank_gate.sv
module sram_bank_gate
    import sbg_pkg::*;
#(
    parameter int HOLD_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic acc_en_n,
    input  logic bank_sel,
    input  logic pwr_fail,
    input  logic batt_mode,
    output logic bank0_ce_n,
    output logic bank1_ce_n,
    output logic wr_prot
);
    pwr_flags_t raw_flags;
    pwr_flags_t sync_flags;
    logic       blocked;
    bank_ce_t   ce;

    assign raw_flags = '{pwr_fail: pwr_fail, batt: batt_mode};

    sbg_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (FLAG_W),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_flags),
        .q  (sync_flags)
    );

    sbg_holdoff #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_holdoff (
        .clk    (clk),
        .rst    (rst),
        .flags  (sync_flags),
        .blocked(blocked)
    );

    sbg_decode u_decode (
        .en_n   (acc_en_n),
        .sel    (bank_sel),
        .blocked(blocked),
        .ce     (ce)
    );

    assign bank0_ce_n = ce.ce0_n;
    assign bank1_ce_n = ce.ce1_n;
    assign wr_prot    = blocked;

    // cycles since reset release, saturating; only qualifies latency checks
    logic [1:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (rst)                   since_rst_q <= '0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    // R2: the two banks are never enabled together
    p_bank_mutex_r2: assert property (@(posedge clk) disable iff (rst)
        !(!bank0_ce_n && !bank1_ce_n));

    // R4: nothing is enabled while write protection is up
    p_blocked_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        wr_prot |-> (bank0_ce_n && bank1_ce_n));

    // R5: a power-fail seen at the pin blocks after the sync latency
    p_pf_latency_r5: assert property (@(posedge clk) disable iff (rst)
        ((since_rst_q >= 2'd2) && $past(pwr_fail, 2)) |=> wr_prot);

    // R6: battery mode blocks with the same latency
    p_batt_latency_r6: assert property (@(posedge clk) disable iff (rst)
        ((since_rst_q >= 2'd2) && $past(batt_mode, 2)) |=> wr_prot);

endmodule

// File: tb/test_sram_bank_gate.sv
module test_sram_bank_gate;
    localparam int HOLD = 8;

    logic clk = 1'b0;
    logic rst;
    logic acc_en_n, bank_sel, pwr_fail, batt_mode;
    logic bank0_ce_n, bank1_ce_n, wr_prot;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    sram_bank_gate #(.HOLD_CYCLES(HOLD)) i_sram_bank_gate (
        .clk       (clk),
        .rst       (rst),
        .acc_en_n  (acc_en_n),
        .bank_sel  (bank_sel),
        .pwr_fail  (pwr_fail),
        .batt_mode (batt_mode),
        .bank0_ce_n(bank0_ce_n),
        .bank1_ce_n(bank1_ce_n),
        .wr_prot   (wr_prot)
    );

    // vector: {acc_en_n, bank_sel, exp bank0_ce_n, exp bank1_ce_n}
    localparam logic [3:0] VEC [0:5] = '{
        4'b0001, 4'b0110, 4'b1011, 4'b1111, 4'b0001, 4'b0110
    };

    task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: {ce0,ce1,wp} actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic logic [2:0] outs();
        return {bank0_ce_n, bank1_ce_n, wr_prot};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; acc_en_n = 1'b0; bank_sel = 1'b0; pwr_fail = 1'b0; batt_mode = 1'b0;
        tick(4);
        chk("R9 during reset", outs(), 3'b111);
        rst = 1'b0;
        tick(1);
        chk("R9 after reset", outs(), 3'b111);
        tick(HOLD);
        chk("R9 holdoff after reset", outs(), 3'b111);
        tick(4);
        chk("R9 released after holdoff", outs(), 3'b010);

        // table walk for R1, R2, R3
        for (int i = 0; i < 6; i++) begin
            acc_en_n = VEC[i][3];
            bank_sel = VEC[i][2];
            #1;
            chk("R1/R2/R3 decode", outs(), {VEC[i][1:0], 1'b0});
            tick(1);
        end

        // R3: bank select ignored with enable high
        acc_en_n = 1'b1; bank_sel = 1'b0; #1;
        chk("R3 sel low", outs(), 3'b110);
        bank_sel = 1'b1; #1;
        chk("R3 sel high", outs(), 3'b110);

        // R5: power-fail latency
        acc_en_n = 1'b0; bank_sel = 1'b1;
        tick(1);
        pwr_fail = 1'b1;
        tick(2);
        chk("R5 not yet blocked", outs(), 3'b100);
        tick(1);
        chk("R5 blocked on third edge", outs(), 3'b111);

        // R4: inputs ignored while blocked
        for (int i = 0; i < 4; i++) begin
            acc_en_n = i[1]; bank_sel = i[0]; #1;
            chk("R4 forced off", outs(), 3'b111);
        end
        acc_en_n = 1'b0; bank_sel = 1'b0;

        // R7: holdoff length after release
        tick(1);
        pwr_fail = 1'b0;
        tick(HOLD + 2);
        chk("R7 still blocked at last holdoff clock", outs(), 3'b111);
        tick(1);
        chk("R7 released", outs(), 3'b010);

        // R7: glitch during holdoff restarts the count
        pwr_fail = 1'b1;
        tick(3);
        pwr_fail = 1'b0;
        tick(4);
        pwr_fail = 1'b1;
        tick(1);
        pwr_fail = 1'b0;
        tick(HOLD + 2);
        chk("R7 restarted holdoff still blocked", outs(), 3'b111);
        tick(1);
        chk("R7 restarted holdoff released", outs(), 3'b010);

        // R6: battery mode
        batt_mode = 1'b1;
        tick(2);
        chk("R6 not yet blocked", outs(), 3'b010);
        tick(1);
        chk("R6 blocked", outs(), 3'b111);
        acc_en_n = 1'b0; bank_sel = 1'b1; #1;
        chk("R8 wp with battery", outs(), 3'b111);
        batt_mode = 1'b0;
        tick(HOLD + 2);
        chk("R6 holdoff", outs(), 3'b111);
        tick(1);
        chk("R8 wp low when released", outs(), 3'b100);

        // R9: reset mid-operation returns to protected state
        rst = 1'b1;
        tick(1);
        chk("R9 reset reasserted", outs(), 3'b111);
        rst = 1'b0;
        tick(HOLD + 6);
        chk("R9 recovered", outs(), 3'b100);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule